// File: doc/BRIEF.md
# Alarm-Centred Frame Window Recorder

This block follows a stream of frame tokens and writes each frame's index into a ring of slots. When an alarm is seen, it fixes a window that holds a set number of frames from before the alarm and a set number from after it. The pre-alarm span is 8 seconds and the post-alarm span is 3 seconds. Both are turned into frame counts from a frame-rate parameter. Once the post-alarm tail is in the ring, the block freezes. From then on it writes no frames and ignores every alarm, until a store-done pulse from downstream says the window has been saved. The pulse re-arms the block.

While frozen, the block reports two slot pointers: the first slot of the window, and one past its last slot. It also reports the frame indices held in the first and the last slot, and a flag for an alarm that came before the full pre-alarm history existed. Downstream logic uses the pointers to drain the frozen frames. Pixel storage, encoding and disk writes are done elsewhere.

Top module: `alarm_window_capture`

## Requirements
- R1: After reset, busy, captureDone and shortHistory are 0, and winStart and winEnd are 0.
- R2: alarmIn passes through a two-flop synchronizer and a rising-edge detector, so an alarm held high starts at most one capture. If alarmIn is still high when the block re-arms, no new capture starts.
- R3: With at least PRE_FRAMES frames of history, an accepted alarm sets winStart = (P - PRE_FRAMES) mod DEPTH and shortHistory = 0. P is the ring slot the next frame would be written to when the alarm is accepted.
- R4: winEnd = (P + POST_FRAMES) mod DEPTH. captureDone rises after POST_FRAMES more frames have been written. lastIdx is the index of the last of those frames.
- R5: No frame is dropped from reset until the tail is complete. With frames numbered consecutively, lastIdx - firstIdx = PRE_FRAMES + POST_FRAMES - 1 for a full-history window.
- R6: busy is 1 from the cycle after an alarm is accepted until release. captureDone is 1 only while the window is frozen, and never without busy.
- R7: Alarms during the tail or while frozen leave winStart, winEnd and the window contents unchanged.
- R8: Frames arriving while frozen are not written. firstIdx and lastIdx keep their values even when more than DEPTH such frames arrive.
- R9: storeDone while frozen clears busy and captureDone on the next cycle. storeDone at any other time is ignored.
- R10: An alarm with only H < PRE_FRAMES frames of history sets winStart = (P - H) mod DEPTH, which is the oldest frame, and sets shortHistory = 1.
- R11: Slot pointers wrap modulo DEPTH, so a window may straddle the end of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | One-cycle strobe per arriving frame |
| frameIdx | input | IDX_W | Index carried by the arriving frame |
| alarmIn | input | 1 | Asynchronous alarm level |
| storeDone | input | 1 | Pulse: frozen window has been saved |
| busy | output | 1 | Capture in progress or window frozen |
| captureDone | output | 1 | Window frozen and ready to drain |
| shortHistory | output | 1 | Window began with less than full history |
| winStart | output | PTR_W | First slot of the window |
| winEnd | output | PTR_W | Slot one past the last window slot |
| firstIdx | output | IDX_W | Frame index held in slot winStart |
| lastIdx | output | IDX_W | Frame index held in the slot before winEnd |

## Verification
The main function is tried with three alarm patterns.

- An early alarm, before the history is full, separates the oldest-frame start from the fixed-offset start.
- A level alarm held high across a full-history capture and its release shows single triggering, and also shows the window wrapping around the ring.
- Short alarm pulses, one accepted and one arriving mid-tail, show that late alarms cannot move the window.

A long burst of frames while frozen would overwrite the window's first slot if writes were not gated. Store-done pulses sent mid-tail and after freezing separate an ignored release from a real one.

// File: rtl/awc_pkg.sv
package awc_pkg;
  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_POST   = 2'd2,
    ST_FROZEN = 2'd3
  } awcState_e;

  typedef struct packed {
    logic wrEn;
    logic latchAlarm;
  } awcStrobe_t;
endpackage

// File: rtl/awc_edge_sync.sv
module awc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= din;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[STAGES-1];

  assign rise = syncQ[STAGES-1] & ~lastQ;
endmodule

// File: rtl/awc_ctrl.sv
module awc_ctrl
  import awc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameValid,
  input  logic       alarmRise,
  input  logic       storeDone,
  input  logic       histFull,
  input  logic       atEnd,
  output awcStrobe_t strobe,
  output logic       busy,
  output logic       captureDone
);
  awcState_e state, stateNext;
  logic      accepting;

  assign accepting = (state == ST_FILL) || (state == ST_ARMED);

  always_comb begin
    stateNext = state;
    case (state)
      ST_FILL:   if (alarmRise) stateNext = ST_POST;
                 else if (histFull) stateNext = ST_ARMED;
      ST_ARMED:  if (alarmRise) stateNext = ST_POST;
      ST_POST:   if (atEnd) stateNext = ST_FROZEN;
      ST_FROZEN: if (storeDone) stateNext = histFull ? ST_ARMED : ST_FILL;
      default:   stateNext = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_FILL;
    else       state <= stateNext;

  always_comb begin
    strobe.wrEn       = frameValid && (accepting || (state == ST_POST && !atEnd));
    strobe.latchAlarm = alarmRise && accepting;
  end

  assign busy        = (state == ST_POST) || (state == ST_FROZEN);
  assign captureDone = (state == ST_FROZEN);
endmodule

// File: rtl/awc_datapath.sv
module awc_datapath
  import awc_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int IDX_W       = 16,
  parameter int PRE_FRAMES  = 32,
  parameter int POST_FRAMES = 12,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int HIST_W     = $clog2(PRE_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  awcStrobe_t       strobe,
  input  logic [IDX_W-1:0] frameIdx,
  output logic             histFull,
  output logic             atEnd,
  output logic [PTR_W-1:0] winStart,
  output logic [PTR_W-1:0] winEnd,
  output logic             shortHistory,
  output logic [IDX_W-1:0] firstIdx,
  output logic [IDX_W-1:0] lastIdx
);
  logic [PTR_W-1:0]  wrPtr;
  logic [HIST_W-1:0] histCnt;
  logic [IDX_W-1:0]  ring [DEPTH];

  function automatic logic [PTR_W-1:0] ptrAdd(input logic [PTR_W-1:0] a, input int n);
    int s;
    s = int'(a) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  function automatic logic [PTR_W-1:0] ptrSub(input logic [PTR_W-1:0] a, input int n);
    int s;
    s = int'(a) - n;
    if (s < 0) s = s + DEPTH;
    return PTR_W'(s);
  endfunction

  assign histFull = (int'(histCnt) == PRE_FRAMES);
  assign atEnd    = (wrPtr == winEnd);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      wrPtr   <= '0;
      histCnt <= '0;
    end else if (strobe.wrEn) begin
      wrPtr <= ptrAdd(wrPtr, 1);
      if (!histFull) histCnt <= histCnt + 1'b1;
    end

  always_ff @(posedge clk)
    if (strobe.wrEn) ring[wrPtr] <= frameIdx;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      winStart     <= '0;
      winEnd       <= '0;
      shortHistory <= 1'b0;
    end else if (strobe.latchAlarm) begin
      winStart     <= ptrSub(wrPtr, histFull ? PRE_FRAMES : int'(histCnt));
      winEnd       <= ptrAdd(wrPtr, POST_FRAMES);
      shortHistory <= !histFull;
    end

  assign firstIdx = ring[winStart];
  assign lastIdx  = ring[ptrSub(winEnd, 1)];
endmodule

// File: rtl/alarm_window_capture.sv
module alarm_window_capture
  import awc_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int IDX_W        = 16,
  parameter int FRAME_RATE   = 4,
  parameter int PRE_SECONDS  = 8,
  parameter int POST_SECONDS = 3,
  localparam int PTR_W       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic [IDX_W-1:0] frameIdx,
  input  logic             alarmIn,
  input  logic             storeDone,
  output logic             busy,
  output logic             captureDone,
  output logic             shortHistory,
  output logic [PTR_W-1:0] winStart,
  output logic [PTR_W-1:0] winEnd,
  output logic [IDX_W-1:0] firstIdx,
  output logic [IDX_W-1:0] lastIdx
);
  localparam int PRE_FRAMES  = PRE_SECONDS * FRAME_RATE;
  localparam int POST_FRAMES = POST_SECONDS * FRAME_RATE;

  awcStrobe_t strobe;
  logic       alarmRise, histFull, atEnd;

  awc_edge_sync #(.STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .din(alarmIn), .rise(alarmRise)
  );

  awc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .alarmRise(alarmRise),
    .storeDone(storeDone), .histFull(histFull), .atEnd(atEnd),
    .strobe(strobe), .busy(busy), .captureDone(captureDone)
  );

  awc_datapath #(
    .DEPTH(DEPTH), .IDX_W(IDX_W),
    .PRE_FRAMES(PRE_FRAMES), .POST_FRAMES(POST_FRAMES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameIdx(frameIdx),
    .histFull(histFull), .atEnd(atEnd), .winStart(winStart), .winEnd(winEnd),
    .shortHistory(shortHistory), .firstIdx(firstIdx), .lastIdx(lastIdx)
  );
endmodule

// File: rtl/awc_checker.sv
module awc_checker #(
  parameter int PTR_W = 6,
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             storeDone,
  input logic             busy,
  input logic             captureDone,
  input logic [PTR_W-1:0] winStart,
  input logic [PTR_W-1:0] winEnd,
  input logic [IDX_W-1:0] firstIdx,
  input logic [IDX_W-1:0] lastIdx
);
  assert_done_needs_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    captureDone |-> busy);

  assert_frozen_contents_R8: assert property (@(posedge clk) disable iff (!rstN)
    (captureDone && !storeDone) |=>
      (captureDone && $stable(firstIdx) && $stable(lastIdx) && $stable(winEnd)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (captureDone && storeDone) |=> (!busy && !captureDone));

  assert_window_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(winStart) && $stable(winEnd)));

  assert_done_from_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(captureDone) |-> $past(busy));
endmodule

bind alarm_window_capture awc_checker #(.PTR_W(PTR_W), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .storeDone(storeDone), .busy(busy),
  .captureDone(captureDone), .winStart(winStart), .winEnd(winEnd),
  .firstIdx(firstIdx), .lastIdx(lastIdx)
);

// File: tb/sim_alarm_window_capture.sv
module sim_alarm_window_capture;
  localparam int DEPTH = 64;
  localparam int IDX_W = 16;
  localparam int PRE   = 32;
  localparam int POST  = 12;
  localparam int PTR_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [IDX_W-1:0] frameIdx = '0;
  logic alarmIn = 1'b0;
  logic storeDone = 1'b0;
  logic busy, captureDone, shortHistory;
  logic [PTR_W-1:0] winStart, winEnd;
  logic [IDX_W-1:0] firstIdx, lastIdx;

  always #2.5 clk = ~clk;

  alarm_window_capture u0 (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameIdx(frameIdx),
    .alarmIn(alarmIn), .storeDone(storeDone), .busy(busy),
    .captureDone(captureDone), .shortHistory(shortHistory),
    .winStart(winStart), .winEnd(winEnd), .firstIdx(firstIdx), .lastIdx(lastIdx)
  );

  int nChecks = 0;
  int nFails  = 0;
  int mWr = 0, mHist = 0, mPhase = 0, mPostLeft = 0, nextIdx = 0;
  int mMem [DEPTH];
  int expStart = 0, expEnd = 0, expShort = 0;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendFrame();
    @(negedge clk);
    frameValid = 1'b1;
    frameIdx   = IDX_W'(nextIdx);
    if (mPhase == 0 || (mPhase == 1 && mPostLeft > 0)) begin
      mMem[mWr] = nextIdx;
      mWr = (mWr + 1) % DEPTH;
      if (mHist < PRE) mHist++;
      if (mPhase == 1) begin
        mPostLeft--;
        if (mPostLeft == 0) mPhase = 2;
      end
    end
    nextIdx++;
    @(negedge clk);
    frameValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendFrames(input int n);
    for (int i = 0; i < n; i++) sendFrame();
  endtask

  task automatic modelAlarm();
    if (mPhase == 0) begin
      expStart  = (mWr - ((mHist < PRE) ? mHist : PRE) + DEPTH) % DEPTH;
      expEnd    = (mWr + POST) % DEPTH;
      expShort  = (mHist < PRE) ? 1 : 0;
      mPhase    = 1;
      mPostLeft = POST;
    end
  endtask

  task automatic pulseAlarm();
    @(negedge clk);
    alarmIn = 1'b1;
    idle(3);
    alarmIn = 1'b0;
    modelAlarm();
    idle(4);
  endtask

  task automatic pulseStore();
    @(negedge clk);
    storeDone = 1'b1;
    @(negedge clk);
    storeDone = 1'b0;
    if (mPhase == 2) mPhase = 0;
    @(negedge clk);
  endtask

  task automatic checkWindow(input string tag);
    chk({tag, " R4 captureDone"}, int'(captureDone), 1);
    chk({tag, " R6 busy"}, int'(busy), 1);
    chk({tag, " R3/R10 winStart"}, int'(winStart), expStart);
    chk({tag, " R4/R11 winEnd"}, int'(winEnd), expEnd);
    chk({tag, " R10 shortHistory"}, int'(shortHistory), expShort);
    chk({tag, " R3 firstIdx"}, int'(firstIdx), mMem[expStart]);
    chk({tag, " R4 lastIdx"}, int'(lastIdx), mMem[(expEnd + DEPTH - 1) % DEPTH]);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(2);
    chk("R1 busy", int'(busy), 0);
    chk("R1 captureDone", int'(captureDone), 0);
    chk("R1 shortHistory", int'(shortHistory), 0);
    chk("R1 winStart", int'(winStart), 0);
    chk("R1 winEnd", int'(winEnd), 0);
  endtask

  task automatic testShortHistory();
    int keepFirst, keepLast, keepStart;
    nextIdx = 100;
    sendFrames(10);
    pulseAlarm();
    chk("R6 busy after accept", int'(busy), 1);
    chk("R6 no done during tail", int'(captureDone), 0);
    sendFrames(POST + 5);
    idle(2);
    checkWindow("short");
    keepStart = int'(winStart);
    pulseAlarm();
    chk("R7 start after frozen alarm", int'(winStart), keepStart);
    keepFirst = int'(firstIdx);
    keepLast  = int'(lastIdx);
    sendFrames(DEPTH + 6);
    chk("R8 firstIdx after frozen frames", int'(firstIdx), keepFirst);
    chk("R8 lastIdx after frozen frames", int'(lastIdx), keepLast);
    pulseStore();
    chk("R9 busy after release", int'(busy), 0);
    chk("R9 done after release", int'(captureDone), 0);
  endtask

  task automatic testLevelWrap();
    nextIdx = 200;
    sendFrames(40);
    @(negedge clk);
    alarmIn = 1'b1;
    modelAlarm();
    idle(5);
    sendFrames(POST / 2);
    pulseStore();
    chk("R9 store mid-tail ignored", int'(busy), 1);
    sendFrames(POST - POST / 2 + 2);
    idle(2);
    checkWindow("level");
    chk("R5 contiguous window", int'(lastIdx) - int'(firstIdx), PRE + POST - 1);
    chk("R11 window wraps", int'(winEnd < winStart), 1);
    pulseStore();
    idle(8);
    chk("R2 held alarm no retrigger", int'(busy), 0);
    sendFrames(3);
    chk("R2 still idle with frames", int'(busy), 0);
    @(negedge clk);
    alarmIn = 1'b0;
    idle(4);
  endtask

  task automatic testLateAlarm();
    nextIdx = 500;
    sendFrames(5);
    pulseAlarm();
    sendFrames(4);
    pulseAlarm();
    chk("R7 start after tail alarm", int'(winStart), expStart);
    chk("R7 end after tail alarm", int'(winEnd), expEnd);
    sendFrames(POST);
    idle(2);
    checkWindow("late");
    pulseStore();
    chk("R9 final release", int'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    testReset();
    testShortHistory();
    testLevelWrap();
    testLateAlarm();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule